// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host-facing register port of a hardware cursor generator. The host sees four 16-bit ports, chosen by a 2-bit select. Two of them load a 9-bit internal pointer, one byte at a time. Through the other two it reads or writes what the pointer addresses:

- the register port reaches a small file of byte-wide control registers;
- the cursor-map port reaches 16-bit words of an external cursor bitmap RAM.

Every data access moves the pointer forward by one. A sequence of registers or bitmap words can therefore be streamed without reloading the address.

The register file drives the generator directly: a command byte and six 12-bit coordinates for cursor position and window origin and size. Bitmap traffic passes straight to a synchronous RAM port that sits outside the block. A read returns its data one cycle after the request, flagged by a valid strobe.

Top module: `cursor_regport`

## Requirements
- R1: Port select codes are 0 = address low, 1 = address high, 2 = cursor map, 3 = register data. A write to address low loads pointer bits 7:0 from write-data bits 7:0 and leaves pointer bit 8 unchanged. A read of address low returns pointer bits 7:0 on both bytes of the read data.
- R2: A write to address high loads pointer bit 8 from write-data bit 0 and ignores the other bits. A read of address high returns pointer bit 8 in bit 0 of both bytes, with all other bits zero.
- R3: Every read or write on the register or cursor-map port advances the pointer by one, and 0x1FF wraps to 0x000. Accesses to the address ports never advance it. The pointer is visible at all times on ramAddr.
- R4: A register-port write stores write-data bits 7:0. A register-port read returns the byte of the addressed register on bits 15:8 and on bits 7:0, with hostRvalid high in the cycle after the request.
- R5: The register map is:
  - 0x000: command, driven on cmdReg;
  - 0x001/0x002: cursor X low/high;
  - 0x003/0x004: cursor Y low/high;
  - 0x005/0x006: window X low/high;
  - 0x007/0x008: window Y low/high;
  - 0x009/0x00A: window width low/high;
  - 0x00B/0x00C: window height low/high.

  Each low/high pair forms the 12-bit output {high[3:0], low[7:0]}.
- R6: The high registers of a pair (0x002, 0x004, 0x006, 0x008, 0x00A, 0x00C) keep only bits 3:0. Their bits 7:4 read back as zero.
- R7: Register-port writes to pointer values 0x00D to 0x1FF change no register, and register-port reads there return 0x0000. Both still advance the pointer.
- R8: A cursor-map write asserts ramWe in the same cycle, with ramAddr equal to the pointer before the advance and ramWdata equal to the full 16-bit write data.
- R9: A cursor-map read asserts ramRe in the same cycle at the current pointer. In the next cycle, hostRdata carries the RAM word of that pre-advance address.
- R10: Reset clears the pointer, all registers and hostRvalid to zero.
- R11: If hostWr and hostRd are both high, only the write is performed. No read strobe is issued and hostRvalid stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostSel | input | 2 | Port select (0 addr low, 1 addr high, 2 map, 3 reg) |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, valid with hostRvalid |
| hostRvalid | output | 1 | Read data valid, one cycle after hostRd |
| ramAddr | output | 9 | Cursor RAM address (current pointer) |
| ramWe | output | 1 | Cursor RAM write enable |
| ramRe | output | 1 | Cursor RAM read enable |
| ramWdata | output | 16 | Cursor RAM write data |
| ramRdata | input | 16 | Cursor RAM read data, one cycle after ramRe |
| cmdReg | output | 8 | Command register |
| cursorX | output | 12 | Cursor X position |
| cursorY | output | 12 | Cursor Y position |
| windowX | output | 12 | Window X origin |
| windowY | output | 12 | Window Y origin |
| windowW | output | 12 | Window width |
| windowH | output | 12 | Window height |

## Verification
The pointer is always visible on ramAddr, so a wrong advance, a missing wrap or a bad byte load shows up at the clock edge after the faulty access. A corrupted register shows on its coordinate output in the same cycle it is written. It also shows one cycle after a read of it, as a mismatch between the two mirrored bytes or a wrong value. A bitmap read paired with the wrong address shows up as a wrong word in the cycle after the request.

// File: rtl/cursor_regport_pkg.sv
package cursor_regport_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR_LO = 2'd0,
    PORT_ADDR_HI = 2'd1,
    PORT_MAP     = 2'd2,
    PORT_REG     = 2'd3
  } portSel_e;

  typedef struct packed {
    logic ldLo;
    logic ldHi;
    logic regWr;
    logic mapWr;
    logic rdLo;
    logic rdHi;
    logic regRd;
    logic mapRd;
    logic adv;
  } strobe_t;
endpackage

// File: rtl/cursor_regport_ctrl.sv
module cursor_regport_ctrl
  import cursor_regport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  output strobe_t    stb,
  output logic       rdValid,
  output logic       rdFromMap
);
  logic rdTake;
  assign rdTake = hostRd && !hostWr;  // write wins (R11)

  always_comb begin
    stb       = '0;
    stb.ldLo  = hostWr && (hostSel == PORT_ADDR_LO);
    stb.ldHi  = hostWr && (hostSel == PORT_ADDR_HI);
    stb.mapWr = hostWr && (hostSel == PORT_MAP);
    stb.regWr = hostWr && (hostSel == PORT_REG);
    stb.rdLo  = rdTake && (hostSel == PORT_ADDR_LO);
    stb.rdHi  = rdTake && (hostSel == PORT_ADDR_HI);
    stb.mapRd = rdTake && (hostSel == PORT_MAP);
    stb.regRd = rdTake && (hostSel == PORT_REG);
    stb.adv   = stb.mapWr || stb.regWr || stb.mapRd || stb.regRd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid   <= 1'b0;
      rdFromMap <= 1'b0;
    end else begin
      rdValid   <= rdTake;
      rdFromMap <= stb.mapRd;
    end
  end

  // R11: a colliding write and read produces no read response
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    (hostWr && hostRd) |=> !rdValid);
  // R3: at most one access kind per cycle
  a_r3_one_access: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.ldLo, stb.ldHi, stb.regWr, stb.mapWr,
              stb.rdLo, stb.rdHi, stb.regRd, stb.mapRd}));
endmodule

// File: rtl/cursor_regport_dp.sv
module cursor_regport_dp
  import cursor_regport_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int REG_COUNT = 13,
  parameter int COORD_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              stb,
  input  logic                 rdFromMap,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    ramRdata,
  output logic [ADDR_W-1:0]    ptr,
  output logic [DATA_W-1:0]    rdData,
  output logic [7:0]           cmdByte,
  output logic [COORD_W-1:0]   coords [(REG_COUNT-1)/2]
);
  localparam int HI_BITS   = COORD_W - 8;
  localparam int PAIRS     = (REG_COUNT - 1) / 2;
  localparam int PTR_HI_W  = ADDR_W - 8;

  logic [7:0] regs [REG_COUNT];
  logic [7:0] byteSel;
  logic [7:0] rdByteQ;
  logic [8*REG_COUNT-1:0] regFlat;

  // pointer
  always_ff @(posedge clk) begin
    if (rst)            ptr <= '0;
    else if (stb.ldLo)  ptr[7:0] <= wrData[7:0];
    else if (stb.ldHi)  ptr[ADDR_W-1:8] <= wrData[PTR_HI_W-1:0];
    else if (stb.adv)   ptr <= ptr + 1'b1;
  end

  // register file
  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam bit IS_HI = (i > 0) && (i % 2 == 0);
    localparam logic [7:0] KEEP = IS_HI ? 8'((1 << HI_BITS) - 1) : 8'hFF;
    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else if (stb.regWr && (ptr == ADDR_W'(i))) regs[i] <= wrData[7:0] & KEEP;
    end
    assign regFlat[8*i +: 8] = regs[i];
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_coord
    assign coords[k] = {regs[2*k+2][HI_BITS-1:0], regs[2*k+1]};
  end
  assign cmdByte = regs[0];

  always_comb begin
    byteSel = '0;
    for (int i = 0; i < REG_COUNT; i++)
      if (ptr == ADDR_W'(i)) byteSel = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst)            rdByteQ <= '0;
    else if (stb.rdLo)  rdByteQ <= ptr[7:0];
    else if (stb.rdHi)  rdByteQ <= 8'(ptr[ADDR_W-1:8]);
    else if (stb.regRd) rdByteQ <= byteSel;
  end

  assign rdData = rdFromMap ? ramRdata : {rdByteQ, rdByteQ};

  // R3: a data access moves the pointer forward by exactly one
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    stb.adv |=> ptr == ADDR_W'($past(ptr) + 1'b1));
  // R1: low address load takes the low data byte
  a_r1_load_lo: assert property (@(posedge clk) disable iff (rst)
    stb.ldLo |=> ptr[7:0] == $past(wrData[7:0]));
  // R7: register writes outside the map leave the file untouched
  a_r7_ignore: assert property (@(posedge clk) disable iff (rst)
    (stb.regWr && ptr >= ADDR_W'(REG_COUNT)) |=> $stable(regFlat));
endmodule

// File: rtl/cursor_regport.sv
module cursor_regport
  import cursor_regport_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int REG_COUNT = 13,
  parameter int COORD_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         hostSel,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               hostRvalid,
  output logic [ADDR_W-1:0]  ramAddr,
  output logic               ramWe,
  output logic               ramRe,
  output logic [DATA_W-1:0]  ramWdata,
  input  logic [DATA_W-1:0]  ramRdata,
  output logic [7:0]         cmdReg,
  output logic [COORD_W-1:0] cursorX,
  output logic [COORD_W-1:0] cursorY,
  output logic [COORD_W-1:0] windowX,
  output logic [COORD_W-1:0] windowY,
  output logic [COORD_W-1:0] windowW,
  output logic [COORD_W-1:0] windowH
);
  localparam int PAIRS = (REG_COUNT - 1) / 2;

  strobe_t            stb;
  logic               rdFromMap;
  logic [COORD_W-1:0] coords [PAIRS];

  cursor_regport_ctrl u_ctrl (
    .clk(clk), .rst(rst), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .stb(stb), .rdValid(hostRvalid), .rdFromMap(rdFromMap)
  );

  cursor_regport_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .COORD_W(COORD_W)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .rdFromMap(rdFromMap), .wrData(hostWdata),
    .ramRdata(ramRdata), .ptr(ramAddr), .rdData(hostRdata), .cmdByte(cmdReg),
    .coords(coords)
  );

  assign ramWe    = stb.mapWr;
  assign ramRe    = stb.mapRd;
  assign ramWdata = hostWdata;

  assign cursorX = coords[0];
  assign cursorY = coords[1];
  assign windowX = coords[2];
  assign windowY = coords[3];
  assign windowW = coords[4];
  assign windowH = coords[5];

  // R4: byte-wide responses are mirrored on both halves
  a_r4_mirror: assert property (@(posedge clk) disable iff (rst)
    (hostRvalid && !rdFromMap) |-> hostRdata[15:8] == hostRdata[7:0]);
  // R8: RAM writes only come from host map writes
  a_r8_we_source: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (hostWr && hostSel == PORT_MAP));
  // R9: a lone read is answered in the next cycle
  a_r9_rvalid: assert property (@(posedge clk) disable iff (rst)
    (hostRd && !hostWr) |=> hostRvalid);
endmodule

// File: tb/cursor_regport_test.sv
module cursor_regport_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  hostSel = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostRvalid;
  logic [8:0]  ramAddr;
  logic        ramWe, ramRe;
  logic [15:0] ramWdata, ramRdata;
  logic [7:0]  cmdReg;
  logic [11:0] cursorX, cursorY, windowX, windowY, windowW, windowH;

  int checks = 0, failures = 0;
  logic [15:0] mem [512];
  logic [15:0] rdv;

  always #5 clk = ~clk;

  cursor_regport uut (.*);

  always_ff @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
    if (ramRe) ramRdata <= mem[ramAddr];
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [1:0] sel, logic [15:0] d);
    @(negedge clk); hostSel = sel; hostWdata = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hread(logic [1:0] sel, output logic [15:0] d);
    @(negedge clk); hostSel = sel; hostRd = 1'b1;
    @(negedge clk); hostRd = 1'b0;
    check("R4 rvalid", hostRvalid, 1'b1);
    d = hostRdata;
  endtask

  task automatic setAddr(logic [8:0] a);
    hwrite(2'd0, {8'hA5, a[7:0]});
    hwrite(2'd1, {15'h7FFE, a[8]});
  endtask

  task automatic tReset();
    check("R10 ptr", ramAddr, 9'h0);
    check("R10 cmd", cmdReg, 8'h0);
    check("R10 cursorX", cursorX, 12'h0);
    check("R10 rvalid", hostRvalid, 1'b0);
  endtask

  task automatic tAddr();
    setAddr(9'h1C3);
    check("R1 R2 ptr load", ramAddr, 9'h1C3);
    hread(2'd0, rdv); check("R1 lo readback", rdv, 16'hC3C3);
    hread(2'd1, rdv); check("R2 hi readback", rdv, 16'h0101);
    check("R3 no adv on addr port", ramAddr, 9'h1C3);
    hwrite(2'd0, 16'h0012);
    check("R1 bit8 kept", ramAddr, 9'h112);
  endtask

  task automatic tRegs();
    setAddr(9'h000);
    hwrite(2'd3, 16'h0054);
    for (int i = 1; i <= 12; i++) hwrite(2'd3, 16'(8'(i * 16 + 15)));
    check("R3 ptr after 13 writes", ramAddr, 9'h00D);
    check("R5 cmd", cmdReg, 8'h54);
    check("R5 R6 cursorX", cursorX, 12'hF1F);
    check("R5 R6 cursorY", cursorY, 12'hF3F);
    check("R5 R6 windowX", windowX, 12'hF5F);
    check("R5 R6 windowY", windowY, 12'hF7F);
    check("R5 R6 windowW", windowW, 12'hF9F);
    check("R5 R6 windowH", windowH, 12'hFBF);
    setAddr(9'h001);
    hread(2'd3, rdv); check("R4 read cxlo mirrored", rdv, 16'h1F1F);
    hread(2'd3, rdv); check("R6 cxhi upper zero", rdv, 16'h0F0F);
    check("R3 ptr after reads", ramAddr, 9'h003);
  endtask

  task automatic tIgnore();
    setAddr(9'h00D);
    hwrite(2'd3, 16'h00EE);
    check("R7 adv on ignored write", ramAddr, 9'h00E);
    setAddr(9'h0FF);
    hwrite(2'd3, 16'h0077);
    check("R7 cmd unchanged", cmdReg, 8'h54);
    check("R7 windowH unchanged", windowH, 12'hFBF);
    setAddr(9'h00D);
    hread(2'd3, rdv); check("R7 read zero", rdv, 16'h0000);
  endtask

  task automatic tMap();
    setAddr(9'h040);
    @(negedge clk); hostSel = 2'd2; hostWdata = 16'hBEEF; hostWr = 1'b1;
    #1;
    check("R8 ramWe", ramWe, 1'b1);
    check("R8 ramAddr pre", ramAddr, 9'h040);
    check("R8 ramWdata", ramWdata, 16'hBEEF);
    @(negedge clk); hostWr = 1'b0;
    hwrite(2'd2, 16'h1234);
    check("R3 ptr after map writes", ramAddr, 9'h042);
    setAddr(9'h040);
    hread(2'd2, rdv); check("R9 read word 0x40", rdv, 16'hBEEF);
    hread(2'd2, rdv); check("R9 read word 0x41", rdv, 16'h1234);
  endtask

  task automatic tWrap();
    setAddr(9'h1FF);
    hwrite(2'd2, 16'hCAFE);
    check("R3 wrap", ramAddr, 9'h000);
    setAddr(9'h1FF);
    hread(2'd2, rdv); check("R9 read at 0x1FF", rdv, 16'hCAFE);
    check("R3 wrap on read", ramAddr, 9'h000);
  endtask

  task automatic tCollide();
    setAddr(9'h000);
    @(negedge clk); hostSel = 2'd3; hostWdata = 16'h0033; hostWr = 1'b1; hostRd = 1'b1;
    @(negedge clk); hostWr = 1'b0; hostRd = 1'b0;
    check("R11 no rvalid", hostRvalid, 1'b0);
    check("R11 write done", cmdReg, 8'h33);
    check("R11 single adv", ramAddr, 9'h001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tAddr();
    tRegs();
    tIgnore();
    tMap();
    tWrap();
    tCollide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule